// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block supervises software by counting down on a dedicated watchdog clock that runs independently of the system clock. Software configures a reload value and two enables through a small synchronous register port clocked by the system clock. It then keeps the counter alive by writing an ordered pair of key values to a service register. When the count runs out before a complete pair arrives, the block raises a reset request of fixed length toward the system reset logic. The counter then reloads itself and starts the next timeout.

Register writes stay in the system clock domain. A completed key pair travels to the watchdog domain as a toggle through a synchronizer, which yields exactly one reload per pair. The two enable bits cross through plain synchronizers. The reload value is quasi-static: it is programmed while counting is off. The remaining count and a sticky timeout flag travel back to the register side through a toggle handshake, so software always reads a coherent snapshot.

The reset request can be disabled. Expiry then only sets the sticky timeout flag, which a later valid key pair clears. While counting is disabled, the counter holds the reload value and never requests a reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After system and watchdog reset, `rst_req` is 0, the control register (address 0) reads 0, the reload register (address 1) reads the parameter `RELOAD_RST` (default 0x00FF), and the status register (address 2) reads 0.
- R2: Register map: address 0 is control, where bit 0 enables counting, bit 1 enables reset generation, and all other bits read 0. Address 1 is the 16-bit reload value. Reading address 2 gives the timeout flag in bit 0. Writing address 2 delivers a key. Reading address 3 gives the current count. Written control and reload values read back.
- R3: Writing 0x000A and then 0x0005 to address 2 reloads the counter. Servicing with this pair more often than the timeout keeps `rst_req` low indefinitely.
- R4: A first key other than 0x000A, or any value other than 0x0005 right after 0x000A (including a second 0x000A), abandons the sequence without a reload. Such traffic therefore does not prevent a reset.
- R5: With both enables set and no service, `rst_req` rises every RELOAD+1 watchdog clock cycles. After each expiry the counter reloads and counts down again.
- R6: Each reset request is high for exactly `PULSE_LEN` (default 4) watchdog clock cycles.
- R7: While counting is disabled, the counter holds the reload value, which reads back at address 3, and `rst_req` never rises, even with reset generation enabled.
- R8: With counting enabled and reset generation disabled, expiry leaves `rst_req` low and sets the timeout flag. The flag stays set until a valid key pair clears it.
- R9: The countdown and the reset request continue while the system clock is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock of the register port |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| wd_clk | input | 1 | Independent watchdog clock |
| wd_rst | input | 1 | Synchronous active-high reset, watchdog domain |
| rst_req | output | 1 | Reset request toward the system reset logic |

## Verification
Corruption of the key checker shows up as a spurious reset during correct servicing, or as a missing reset under malformed keys. Either is visible within one timeout of about RELOAD+1 watchdog cycles. A counter fault appears as a changed interval between successive reset pulses, or as a changed pulse width, measured to the exact watchdog cycle. Faults in the snapshot handshake or the flag logic surface as a wrong count or status word a few tens of cycles after the state has settled.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int unsigned WDK_DATA_W = 16;
    localparam int unsigned WDK_CNT_W  = 16;
    localparam int unsigned WDK_ADDR_W = 2;

    localparam logic [WDK_DATA_W-1:0] KEY_FIRST  = 16'h000A;
    localparam logic [WDK_DATA_W-1:0] KEY_SECOND = 16'h0005;

    typedef enum logic [WDK_ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_SVC    = 2'd2,
        REG_COUNT  = 2'd3
    } wdk_reg_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } wdk_key_e;

    typedef struct packed {
        logic rst_en;
        logic cnt_en;
    } wdk_ctrl_t;

    typedef struct packed {
        logic                 tmo;
        logic [WDK_CNT_W-1:0] cnt;
    } wdk_snap_t;

    localparam int unsigned WDK_CTRL_W = $bits(wdk_ctrl_t);
    localparam int unsigned WDK_SNAP_W = $bits(wdk_snap_t);

    function automatic logic [WDK_DATA_W-1:0] ctrl_word(input wdk_ctrl_t c);
        logic [WDK_DATA_W-1:0] w;
        w = '0;
        w[WDK_CTRL_W-1:0] = c;
        return w;
    endfunction
endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= '0;
                else     pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[i] <= '0;
                else     pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/wdk_keychk.sv
module wdk_keychk
    import wdk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  key_wr,
    input  logic [WDK_DATA_W-1:0] key_data,
    output logic                  pair_done
);
    wdk_key_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= KEY_IDLE;
            pair_done <= 1'b0;
        end else begin
            pair_done <= 1'b0;
            if (key_wr) begin
                unique case (state)
                    KEY_IDLE: begin
                        if (key_data == KEY_FIRST) state <= KEY_ARMED;
                    end
                    KEY_ARMED: begin
                        state <= KEY_IDLE;
                        if (key_data == KEY_SECOND) pair_done <= 1'b1;
                    end
                    default: state <= KEY_IDLE;
                endcase
            end
        end
    end

    // Any key other than the first key always leaves the checker idle (R4)
    assert_bad_key_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (key_wr && key_data != KEY_FIRST) |=> state == KEY_IDLE);

    // A completion needs two writes, so it never repeats back to back (R3)
    assert_pair_single_R3: assert property (@(posedge clk) disable iff (rst)
        pair_done |=> !pair_done);
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter logic [WDK_CNT_W-1:0] RELOAD_RST = 16'h00FF
) (
    input  logic                  sys_clk,
    input  logic                  sys_rst,
    input  logic [WDK_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [WDK_DATA_W-1:0] bus_wdata,
    output logic [WDK_DATA_W-1:0] bus_rdata,
    output wdk_ctrl_t             ctrl_q,
    output logic [WDK_CNT_W-1:0]  reload_q,
    output logic                  svc_tgl,
    input  logic                  pub_req_s,
    input  logic [WDK_SNAP_W-1:0] pub_data,
    output logic                  ack_tgl
);
    logic      key_wr;
    logic      pair_done;
    wdk_snap_t snap_q;
    logic      last_req;

    assign key_wr = bus_wr && (wdk_reg_e'(bus_addr) == REG_SVC);

    wdk_keychk u_keychk (
        .clk       (sys_clk),
        .rst       (sys_rst),
        .key_wr    (key_wr),
        .key_data  (bus_wdata),
        .pair_done (pair_done)
    );

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            ctrl_q   <= '0;
            reload_q <= RELOAD_RST;
        end else if (bus_wr) begin
            unique case (wdk_reg_e'(bus_addr))
                REG_CTRL:   ctrl_q   <= wdk_ctrl_t'(bus_wdata[WDK_CTRL_W-1:0]);
                REG_RELOAD: reload_q <= bus_wdata[WDK_CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge sys_clk) begin
        if (sys_rst) svc_tgl <= 1'b0;
        else if (pair_done) svc_tgl <= ~svc_tgl;
    end

    // snapshot receiver: a toggle of the request marks stable data
    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            last_req <= 1'b0;
            snap_q   <= '0;
        end else if (pub_req_s != last_req) begin
            last_req <= pub_req_s;
            snap_q   <= wdk_snap_t'(pub_data);
        end
    end

    assign ack_tgl = last_req;

    always_comb begin
        bus_rdata = '0;
        unique case (wdk_reg_e'(bus_addr))
            REG_CTRL:   bus_rdata = ctrl_word(ctrl_q);
            REG_RELOAD: bus_rdata[WDK_CNT_W-1:0] = reload_q;
            REG_SVC:    bus_rdata[0] = snap_q.tmo;
            REG_COUNT:  bus_rdata[WDK_CNT_W-1:0] = snap_q.cnt;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdk_core.sv
module wdk_core
    import wdk_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic                  wd_clk,
    input  logic                  wd_rst,
    input  wdk_ctrl_t             ctrl_s,
    input  logic [WDK_CNT_W-1:0]  reload_val,
    input  logic                  svc_tgl_s,
    input  logic                  ack_s,
    output logic                  pub_req,
    output logic [WDK_SNAP_W-1:0] pub_data,
    output logic                  rst_req
);
    localparam int unsigned PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam int unsigned HW = $clog2(PULSE_LEN + 1) + 1;

    logic                 svc_prev;
    logic                 svc_pulse;
    logic [WDK_CNT_W-1:0] cnt;
    logic                 fire;
    logic [PW-1:0]        pcnt;
    logic                 tmo_flag;
    logic [HW-1:0]        hi_cnt;

    always_ff @(posedge wd_clk) begin
        if (wd_rst) svc_prev <= 1'b0;
        else        svc_prev <= svc_tgl_s;
    end
    assign svc_pulse = svc_tgl_s ^ svc_prev;

    assign fire = ctrl_s.cnt_en && !svc_pulse && (cnt == '0);

    always_ff @(posedge wd_clk) begin
        if (wd_rst)                          cnt <= reload_val;
        else if (!ctrl_s.cnt_en || svc_pulse) cnt <= reload_val;
        else if (cnt == '0)                  cnt <= reload_val;
        else                                 cnt <= cnt - 1'b1;
    end

    always_ff @(posedge wd_clk) begin
        if (wd_rst) begin
            rst_req <= 1'b0;
            pcnt    <= '0;
        end else if (rst_req) begin
            if (pcnt == '0) rst_req <= 1'b0;
            else            pcnt    <= pcnt - 1'b1;
        end else if (fire && ctrl_s.rst_en) begin
            rst_req <= 1'b1;
            pcnt    <= PW'(PULSE_LEN - 1);
        end
    end

    always_ff @(posedge wd_clk) begin
        if (wd_rst)                        tmo_flag <= 1'b0;
        else if (svc_pulse)                tmo_flag <= 1'b0;
        else if (fire && !ctrl_s.rst_en)   tmo_flag <= 1'b1;
    end

    // snapshot sender: publish a new value once the last one was taken
    always_ff @(posedge wd_clk) begin
        if (wd_rst) begin
            pub_req  <= 1'b0;
            pub_data <= '0;
        end else if (ack_s == pub_req) begin
            pub_req  <= ~pub_req;
            pub_data <= {tmo_flag, cnt};
        end
    end

    // checker support: length of the current high phase of rst_req
    always_ff @(posedge wd_clk) begin
        if (wd_rst)                     hi_cnt <= '0;
        else if (!rst_req)              hi_cnt <= '0;
        else if (hi_cnt != '1)          hi_cnt <= hi_cnt + 1'b1;
    end

    assert_reload_on_service_R3: assert property (@(posedge wd_clk) disable iff (wd_rst)
        (svc_pulse || !ctrl_s.cnt_en) |=> cnt == $past(reload_val));

    assert_countdown_step_R5: assert property (@(posedge wd_clk) disable iff (wd_rst)
        (ctrl_s.cnt_en && !svc_pulse && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    assert_pulse_width_R6: assert property (@(posedge wd_clk) disable iff (wd_rst)
        $fell(rst_req) |-> hi_cnt == HW'(PULSE_LEN));

    assert_no_req_when_idle_R7: assert property (@(posedge wd_clk) disable iff (wd_rst)
        !ctrl_s.cnt_en |=> !$rose(rst_req));

    assert_no_req_gen_off_R8: assert property (@(posedge wd_clk) disable iff (wd_rst)
        !ctrl_s.rst_en |=> !$rose(rst_req));

    assert_flag_sticky_R8: assert property (@(posedge wd_clk) disable iff (wd_rst)
        (tmo_flag && !svc_pulse) |=> tmo_flag);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdk_pkg::*;
#(
    parameter logic [WDK_CNT_W-1:0] RELOAD_RST  = 16'h00FF,
    parameter int unsigned          PULSE_LEN   = 4,
    parameter int unsigned          SYNC_STAGES = 2
) (
    input  logic                  sys_clk,
    input  logic                  sys_rst,
    input  logic [WDK_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [WDK_DATA_W-1:0] bus_wdata,
    output logic [WDK_DATA_W-1:0] bus_rdata,
    input  logic                  wd_clk,
    input  logic                  wd_rst,
    output logic                  rst_req
);
    wdk_ctrl_t             ctrl_q;
    logic [WDK_CTRL_W-1:0] ctrl_s_raw;
    logic [WDK_CNT_W-1:0]  reload_q;
    logic                  svc_tgl;
    logic                  svc_tgl_s;
    logic                  pub_req;
    logic                  pub_req_s;
    logic [WDK_SNAP_W-1:0] pub_data;
    logic                  ack_tgl;
    logic                  ack_s;

    wdk_regs #(.RELOAD_RST(RELOAD_RST)) u_regs (
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl_q),
        .reload_q  (reload_q),
        .svc_tgl   (svc_tgl),
        .pub_req_s (pub_req_s),
        .pub_data  (pub_data),
        .ack_tgl   (ack_tgl)
    );

    wdk_sync #(.W(WDK_CTRL_W), .STAGES(SYNC_STAGES)) u_sync_ctrl (
        .clk (wd_clk), .rst (wd_rst), .d (ctrl_q), .q (ctrl_s_raw)
    );

    wdk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_svc (
        .clk (wd_clk), .rst (wd_rst), .d (svc_tgl), .q (svc_tgl_s)
    );

    wdk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ack (
        .clk (wd_clk), .rst (wd_rst), .d (ack_tgl), .q (ack_s)
    );

    wdk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_pub (
        .clk (sys_clk), .rst (sys_rst), .d (pub_req), .q (pub_req_s)
    );

    wdk_core #(.PULSE_LEN(PULSE_LEN)) u_core (
        .wd_clk     (wd_clk),
        .wd_rst     (wd_rst),
        .ctrl_s     (wdk_ctrl_t'(ctrl_s_raw)),
        .reload_val (reload_q),
        .svc_tgl_s  (svc_tgl_s),
        .ack_s      (ack_s),
        .pub_req    (pub_req),
        .pub_data   (pub_data),
        .rst_req    (rst_req)
    );
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
    localparam int SYS_PERIOD = 10;
    localparam int WD_PERIOD  = 26;

    logic        sys_clk = 1'b0;
    logic        wd_clk  = 1'b0;
    logic        sys_run = 1'b1;
    logic        sys_rst = 1'b1;
    logic        wd_rst  = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int rst_hi = 0;
    bit done = 1'b0;

    always #(SYS_PERIOD/2) if (sys_run) sys_clk = ~sys_clk;
    always #(WD_PERIOD/2) wd_clk = ~wd_clk;

    always @(negedge wd_clk) if (rst_req === 1'b1) rst_hi++;

    keyed_watchdog u_dut (
        .sys_clk (sys_clk), .sys_rst (sys_rst),
        .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .wd_clk (wd_clk), .wd_rst (wd_rst), .rst_req (rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge sys_clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge sys_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge sys_clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wd_wait(input int n);
        repeat (n) @(negedge wd_clk);
    endtask

    task automatic service();
        wr(2'd2, 16'h000A);
        wr(2'd2, 16'h0005);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rst_req after reset", rst_req, 1'b0);
        rd(2'd0, v); check("R1 control reset", v, 16'h0000);
        rd(2'd1, v); check("R1 reload reset", v, 16'h00FF);
        rd(2'd2, v); check("R1 status reset", v, 16'h0000);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        wr(2'd1, 16'h1234);
        rd(2'd1, v); check("R2 reload readback", v, 16'h1234);
        wr(2'd0, 16'h0002);
        rd(2'd0, v); check("R2 control readback", v, 16'h0002);
        wr(2'd0, 16'hFFFC);
        rd(2'd0, v); check("R2 control unused bits", v, 16'h0000);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        int base;
        wr(2'd1, 16'h0123);
        wr(2'd0, 16'h0002);
        base = rst_hi;
        wd_wait(100);
        check("R7 no request while counting off", rst_hi - base, 0);
        rd(2'd3, v); check("R7 count holds reload", v, 16'h0123);
    endtask

    task automatic t_period();
        int n, hi, guard;
        wr(2'd1, 16'd20);
        wr(2'd0, 16'h0003);
        guard = 0;
        while (rst_req !== 1'b1 && guard < 200) begin
            @(negedge wd_clk); guard++;
        end
        check("R5 first expiry seen", rst_req, 1'b1);
        n = 0; hi = 1;
        forever begin
            @(negedge wd_clk); n++;
            if (rst_req !== 1'b1) break;
            hi++;
        end
        check("R6 pulse width", hi, 4);
        guard = 0;
        while (rst_req !== 1'b1 && guard < 200) begin
            @(negedge wd_clk); n++; guard++;
        end
        check("R5 interval between requests", n, 21);
        wr(2'd0, 16'h0000);
        wd_wait(10);
    endtask

    task automatic t_service();
        int base;
        wr(2'd1, 16'd40);
        wr(2'd0, 16'h0003);
        service();
        base = rst_hi;
        for (int i = 0; i < 15; i++) begin
            wd_wait(20);
            service();
        end
        check("R3 timely service keeps rst_req low", rst_hi - base, 0);
    endtask

    task automatic t_badkeys();
        int base;
        base = rst_hi;
        wr(2'd2, 16'h000A); wr(2'd2, 16'h0003);
        wd_wait(10);
        wr(2'd2, 16'h0005);
        wd_wait(10);
        wr(2'd2, 16'h000A); wr(2'd2, 16'h000A); wr(2'd2, 16'h0005);
        wd_wait(10);
        wr(2'd2, 16'h0003); wr(2'd2, 16'h0005);
        wd_wait(40);
        check("R4 malformed keys do not reload", (rst_hi - base) >= 4, 1'b1);
        wr(2'd0, 16'h0000);
        wd_wait(10);
    endtask

    task automatic t_nogen();
        logic [15:0] v;
        int base;
        wr(2'd1, 16'd10);
        wr(2'd0, 16'h0001);
        base = rst_hi;
        wd_wait(60);
        check("R8 no request with generation off", rst_hi - base, 0);
        rd(2'd2, v); check("R8 timeout flag set", v, 16'h0001);
        wr(2'd0, 16'h0000);
        wd_wait(20);
        rd(2'd2, v); check("R8 timeout flag sticky", v, 16'h0001);
        service();
        wd_wait(20);
        rd(2'd2, v); check("R8 flag cleared by service", v, 16'h0000);
    endtask

    task automatic t_sysstop();
        int base;
        wr(2'd1, 16'd30);
        wr(2'd0, 16'h0003);
        service();
        base = rst_hi;
        sys_run = 1'b0;
        wd_wait(100);
        check("R9 request with system clock stopped", (rst_hi - base) >= 4, 1'b1);
        sys_run = 1'b1;
        wd_wait(5);
        wr(2'd0, 16'h0000);
        wd_wait(10);
    endtask

    initial begin
        #(WD_PERIOD * 6);
        @(negedge sys_clk); sys_rst = 1'b0;
        @(negedge wd_clk);  wd_rst  = 1'b0;
        wd_wait(20);
        t_reset();
        t_regmap();
        t_disabled();
        t_period();
        t_service();
        t_badkeys();
        t_nogen();
        t_sysstop();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(SYS_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule